// File: doc/BRIEF.md
# Sequential Modular Multiplier

This block forms the remainder of the product of two unsigned WIDTH-bit operands divided by a WIDTH-bit modulus, r = (x·y) mod m. Its precondition is x < m. The block uses one shared double-width accumulator. In the first phase it performs WIDTH shift-and-add steps. Each step adds y when the current multiplier bit (taken least significant first) is one and halves the running sum. The accumulator then holds the product as a fixed-point value whose integer part is below m. In the second phase it performs WIDTH restoring-division steps on that same register. Each step doubles the partial remainder, compares it with m, and subtracts m when the doubled value is not smaller.

A one-cycle `start` pulse in the idle state captures x, y and m and clears `done`. After exactly 2·WIDTH clock edges the result appears on `r_out` and `done` rises. Both then hold until the next accepted start. Operands need to be stable only in the cycle that carries `start`. The external reset is asynchronous and active low, and its release is synchronised inside the block over two clock edges.

Top module: `modmul_seq`

## Requirements
- R1: While reset is applied, and until the first accepted start after it, `done` is 0 and `r_out` is 0.
- R2: A `start` high at a rising edge while the block is idle is accepted. `done` is 0 after that edge, and the result depends only on the x, y and m present at that edge. Later changes on the operand inputs have no effect.
- R3: For m > 0 and x < m, the value on `r_out` when `done` rises equals (x·y) mod m.
- R4: `done` rises on the 2·WIDTH-th rising edge after the edge that accepted start, and it is 0 at every edge in between.
- R5: Whenever `done` is 1 (after a start with m > 0 and x < m), `r_out` is smaller than the captured m.
- R6: While `done` is 1 and no start is accepted, `done` stays 1 and `r_out` keeps its value whatever the operand inputs do.
- R7: A `start` pulse that arrives while a computation is running is ignored. The running result and its timing are unchanged.
- R8: y may take any WIDTH-bit value, including values of m or above. The cases x = 0, m = 1 and all-ones operands with m = 2^WIDTH − 1 give the correct remainder.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a computation when idle |
| x_in | input | WIDTH | Multiplier operand, must be below m |
| y_in | input | WIDTH | Multiplicand operand, any value |
| m_in | input | WIDTH | Modulus, nonzero |
| r_out | output | WIDTH | Remainder (x·y) mod m |
| done | output | 1 | High when r_out holds a finished result |

## Verification
The bench builds the block with WIDTH = 8. At that width the reference remainder is easy to compute in the bench, and a full computation takes only 16 cycles. This allows a few hundred pseudo-random operand sets to run alongside corners such as m = 1, m = 255 with all-ones operands, and y above m. Every run checks `done` at each of the 16 intermediate edges. Busy-time start pulses, held results and back-to-back starts are also checked at these small counts.

// File: rtl/modmul_pkg.sv
package modmul_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_MUL  = 2'd1,
    PH_DIV  = 2'd2
  } phase_t;
endpackage

// File: rtl/modmul_ctrl.sv
module modmul_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic mul_en,
  output logic div_en,
  output logic fin,
  output logic done
);
  import modmul_pkg::*;

  localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;

  phase_t        phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          last;

  assign last   = (cnt_q == CW'(WIDTH - 1));
  assign load   = (phase_q == PH_IDLE) && start;
  assign mul_en = (phase_q == PH_MUL);
  assign div_en = (phase_q == PH_DIV);
  assign fin    = div_en && last;
  assign done   = done_q;

  // next-state logic
  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    done_d  = done_q;
    case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d = PH_MUL;
          cnt_d   = '0;
          done_d  = 1'b0;
        end
      end
      PH_MUL: begin
        if (last) begin
          phase_d = PH_DIV;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      PH_DIV: begin
        if (last) begin
          phase_d = PH_IDLE;
          done_d  = 1'b1;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end
endmodule

// File: rtl/modmul_dp.sv
module modmul_dp #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             mul_en,
  input  logic             div_en,
  input  logic             fin,
  input  logic [WIDTH-1:0] x_in,
  input  logic [WIDTH-1:0] y_in,
  input  logic [WIDTH-1:0] m_in,
  output logic [WIDTH-1:0] r_out
);
  localparam int W2 = 2 * WIDTH;

  logic [WIDTH-1:0] xs_q, xs_d;
  logic [WIDTH-1:0] y_q, m_q, r_q;
  logic [W2-1:0]    acc_q, acc_d;
  logic             acc_en, xs_en;

  logic [WIDTH-1:0] hi, lo;
  logic [WIDTH:0]   mul_sum;
  logic [W2-1:0]    mul_acc;
  logic [WIDTH:0]   dbl, diff;
  logic [WIDTH-1:0] div_hi;
  logic [W2-1:0]    div_acc;

  assign hi = acc_q[W2-1:WIDTH];
  assign lo = acc_q[WIDTH-1:0];

  // multiply step: add y when the current bit is set, then halve
  assign mul_sum = {1'b0, hi} + (xs_q[0] ? {1'b0, y_q} : '0);
  assign mul_acc = {mul_sum, lo[WIDTH-1:1]};

  // restoring division step on the doubled partial remainder
  assign dbl     = {hi, lo[WIDTH-1]};
  assign diff    = dbl - {1'b0, m_q};
  assign div_hi  = diff[WIDTH] ? dbl[WIDTH-1:0] : diff[WIDTH-1:0];
  assign div_acc = {div_hi, lo[WIDTH-2:0], 1'b0};

  assign acc_en = load | mul_en | div_en;
  assign xs_en  = load | mul_en;

  always_comb begin
    acc_d = acc_q;
    if (load)        acc_d = '0;
    else if (mul_en) acc_d = mul_acc;
    else if (div_en) acc_d = div_acc;
  end

  assign xs_d = load ? x_in : {1'b0, xs_q[WIDTH-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      xs_q  <= '0;
      y_q   <= '0;
      m_q   <= '0;
      r_q   <= '0;
    end else begin
      if (acc_en) acc_q <= acc_d;
      if (xs_en)  xs_q  <= xs_d;
      if (load) begin
        y_q <= y_in;
        m_q <= m_in;
      end
      if (fin)    r_q   <= div_hi;
    end
  end

  assign r_out = r_q;
endmodule

// File: rtl/modmul_seq.sv
module modmul_seq #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] x_in,
  input  logic [WIDTH-1:0] y_in,
  input  logic [WIDTH-1:0] m_in,
  output logic [WIDTH-1:0] r_out,
  output logic             done
);
  logic [1:0] rsync_q;
  logic       rst_int_n;
  logic       load, mul_en, div_en, fin;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  modmul_ctrl #(.WIDTH(WIDTH)) i_ctrl (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .start  (start),
    .load   (load),
    .mul_en (mul_en),
    .div_en (div_en),
    .fin    (fin),
    .done   (done)
  );

  modmul_dp #(.WIDTH(WIDTH)) i_dp (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load   (load),
    .mul_en (mul_en),
    .div_en (div_en),
    .fin    (fin),
    .x_in   (x_in),
    .y_in   (y_in),
    .m_in   (m_in),
    .r_out  (r_out)
  );
endmodule

// File: rtl/modmul_seq_chk.sv
module modmul_seq_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [WIDTH-1:0] x_in,
  input logic [WIDTH-1:0] y_in,
  input logic [WIDTH-1:0] m_in,
  input logic [WIDTH-1:0] r_out,
  input logic             done
);
  localparam int W2   = 2 * WIDTH;
  localparam int LAST = W2 - 1;
  localparam int CCW  = $clog2(W2);

  logic             busy_c;
  logic [CCW-1:0]   cnt_c;
  logic [WIDTH-1:0] lat_x, lat_y, lat_m;
  logic             accept;
  logic             at_last;
  logic             valid_ops;
  logic [W2-1:0]    prod_e, rem_e;

  assign accept    = start && !busy_c;
  assign at_last   = busy_c && (cnt_c == CCW'(LAST));
  assign valid_ops = (lat_m != '0) && (lat_x < lat_m);
  assign prod_e    = {{WIDTH{1'b0}}, lat_x} * {{WIDTH{1'b0}}, lat_y};
  assign rem_e     = (lat_m != '0) ? (prod_e % {{WIDTH{1'b0}}, lat_m}) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_c <= 1'b0;
      cnt_c  <= '0;
      lat_x  <= '0;
      lat_y  <= '0;
      lat_m  <= '0;
    end else if (accept) begin
      busy_c <= 1'b1;
      cnt_c  <= '0;
      lat_x  <= x_in;
      lat_y  <= y_in;
      lat_m  <= m_in;
    end else if (busy_c) begin
      if (at_last) busy_c <= 1'b0;
      else         cnt_c  <= cnt_c + CCW'(1);
    end
  end

  // R2
  start_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !done);

  // R4
  done_on_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    at_last |=> done);

  // R4
  done_low_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_c && !at_last) |=> !done);

  // R3
  result_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && valid_ops) |-> ({{WIDTH{1'b0}}, r_out} == rem_e));

  // R5
  below_modulus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && valid_ops) |-> (r_out < lat_m));

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !accept) |=> (done && $stable(r_out)));
endmodule

bind modmul_seq modmul_seq_chk #(.WIDTH(WIDTH)) i_chk (
  .clk   (clk),
  .rst_n (rst_int_n),
  .start (start),
  .x_in  (x_in),
  .y_in  (y_in),
  .m_in  (m_in),
  .r_out (r_out),
  .done  (done)
);

// File: tb/test_modmul_seq.sv
`timescale 1ns/1ps
module test_modmul_seq;
  localparam int W = 8;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic [W-1:0] x_in, y_in, m_in;
  logic [W-1:0] r_out;
  logic         done;

  int n_chk;
  int n_bad;
  logic [31:0] seed;

  modmul_seq #(.WIDTH(W)) i_modmul_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .x_in  (x_in),
    .y_in  (y_in),
    .m_in  (m_in),
    .r_out (r_out),
    .done  (done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] lcg(input logic [31:0] s);
    return s * 32'd1103515245 + 32'd12345;
  endfunction

  // one computation; poke = pulse start mid-run with other operands
  task automatic run_op(input logic [W-1:0] x, input logic [W-1:0] y,
                        input logic [W-1:0] m, input bit poke, input string req);
    int  exp_r;
    bit  low_ok;
    exp_r = (int'(x) * int'(y)) % int'(m);
    x_in  = x;
    y_in  = y;
    m_in  = m;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    // R2: done falls, later operand changes ignored
    check(done == 1'b0, "R2 done low after start", int'(done), 0);
    x_in = ~x;
    y_in = ~y;
    m_in = 8'hff;
    low_ok = 1'b1;
    for (int k = 1; k < 2 * W; k++) begin
      if (poke && k == 5) begin
        start = 1'b1;
        x_in  = 8'h01;
        y_in  = 8'h01;
        m_in  = 8'h03;
      end
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      if (done) low_ok = 1'b0;
    end
    // R4: low through the run
    check(low_ok, "R4 done low while busy", int'(low_ok), 1);
    @(posedge clk);
    @(negedge clk);
    check(done == 1'b1, "R4 done at edge 2*WIDTH", int'(done), 1);
    check(int'(r_out) == exp_r, req, int'(r_out), exp_r);
    // R5
    check(r_out < m, "R5 result below modulus", int'(r_out), int'(m) - 1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    start = 1'b0;
    x_in  = '0;
    y_in  = '0;
    m_in  = '0;
    repeat (3) @(negedge clk);
    // R1
    check(done == 1'b0, "R1 done in reset", int'(done), 0);
    check(r_out == '0, "R1 r_out in reset", int'(r_out), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(done == 1'b0 && r_out == '0, "R1 idle after reset", int'(r_out), 0);
  endtask

  task automatic t_basic();
    run_op(8'd3, 8'd5, 8'd7, 1'b0, "R3 3*5 mod 7");
    run_op(8'd10, 8'd20, 8'd13, 1'b0, "R3 10*20 mod 13");
    run_op(8'd100, 8'd200, 8'd201, 1'b0, "R3 100*200 mod 201");
  endtask

  task automatic t_corner();
    run_op(8'd0, 8'd255, 8'd97, 1'b0, "R8 x zero");
    run_op(8'd0, 8'd123, 8'd1, 1'b0, "R8 modulus one");
    run_op(8'd254, 8'd255, 8'd255, 1'b0, "R8 all ones");
    run_op(8'd254, 8'd254, 8'd255, 1'b0, "R8 near max");
    run_op(8'd6, 8'd250, 8'd7, 1'b0, "R8 y above m");
    run_op(8'd1, 8'd128, 8'd2, 1'b0, "R8 even modulus");
  endtask

  task automatic t_busy();
    // R7: mid-run start pulse ignored
    run_op(8'd77, 8'd91, 8'd101, 1'b1, "R7 busy start ignored");
  endtask

  task automatic t_hold();
    logic [W-1:0] held;
    bit ok;
    run_op(8'd45, 8'd67, 8'd89, 1'b0, "R3 before hold");
    held = r_out;
    ok = 1'b1;
    for (int k = 0; k < 8; k++) begin
      x_in = 8'(k * 17);
      y_in = 8'(k * 29);
      m_in = 8'(k * 3 + 1);
      @(posedge clk);
      @(negedge clk);
      if (!done || r_out != held) ok = 1'b0;
    end
    // R6
    check(ok, "R6 result held", int'(r_out), int'(held));
  endtask

  task automatic t_sweep();
    logic [W-1:0] m, x, y;
    for (int i = 0; i < 300; i++) begin
      seed = lcg(seed);
      m = seed[15:8] | 8'h01;
      x = 8'(int'(seed[23:16]) % int'(m));
      y = seed[31:24];
      run_op(x, y, m, 1'b0, "R3 sweep");
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    seed  = 32'h1234_5678;
    t_reset();
    t_basic();
    t_corner();
    t_busy();
    t_hold();
    t_sweep();   // back-to-back starts
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end
endmodule